// File: doc/BRIEF.md
# Receive Address and Character Match Filter

This block sits between a serial receiver's shift register and its receive buffer. Each time the receiver finishes a word it pulses `word_valid` with the data bits and the ninth bit. The filter then decides whether the word is an address, whether that address matches, and whether the word is copied into the buffer. A matched address opens a forwarding window. Data words that follow it reach the buffer until the next address arrives. An unmatched address closes the window, and the data words after it are dropped.

Three control bits pick the mode:

| `addr_en` | `addr_mode` | `brk_sel` | Mode |
|---|---|---|---|
| 0 | 0 | any | Plain pass-through |
| 0 | 1 | any | Character search |
| 1 | 0 | any | Ninth-bit addressing |
| 1 | 1 | 0 | Ninth bit plus character match |
| 1 | 1 | 1 | The word that follows a break is the address |

A match raises a sticky flag that software must clear, together with an interrupt pulse. A word that would enter the buffer while the flag is still set is held back and recorded as an overrun. When the word length is shorter than the buffer, the buffer bits above the word read as ones.

Top module: `uart_rx_addr_filter`

## Requirements
- R1: Reset clears `rx_buf` to 0 and clears `rx_ready`, `addr_flag`, `overrun`, `irq_rx` and `irq_addr`. Reset also closes the window, so in an addressing mode a data word received before any address is dropped.
- R2: In pass-through mode (`addr_en`=0, `addr_mode`=0), every received word is written to the buffer and `addr_flag` never sets.
- R3: In character search mode (`addr_en`=0, `addr_mode`=1), every received word is written to the buffer. A word equal to `match_char` also sets `addr_flag` and pulses `irq_addr`.
- R4: In ninth-bit mode (`addr_en`=1, `addr_mode`=0), a word with `word_bit9`=1 is an address. It always matches: it sets `addr_flag`, pulses `irq_addr` and opens the window. Words with `word_bit9`=0 are data.
- R5: With `addr_en`=1, `addr_mode`=1 and `brk_sel`=0, a word with `word_bit9`=1 is an address. It matches only if it equals `match_char`. A match opens the window. A mismatch closes it and does not set the flag.
- R6: With `addr_en`=1, `addr_mode`=1 and `brk_sel`=1, only the first word after a `brk_pulse` is an address. It matches if it equals `match_char` or if its `word_bit9` is 1. Any other word, including one with `word_bit9`=1, is data.
- R7: In the addressing modes an address word is never written to the buffer. Data words are written only while the window is open.
- R8: `word_len` selects a word of `MIN_LEN + word_len` bits (0 gives 5 bits, 3 gives 8 bits). Buffer bits above the word read as 1, and the comparison with `match_char` uses only the word's own bits.
- R9: A word that would be written while `addr_flag` is set is not written. It sets `overrun`, and `rx_buf` and `rx_ready` keep their values.
- R10: `flag_clr` clears `addr_flag` and `overrun`, and `rd_ack` clears `rx_ready`. A new event in the same cycle takes precedence over a clear. The overrun test uses the flag value from before the clear.
- R11: `irq_rx` pulses for one cycle, in the same cycle as the buffer update and `rx_ready`. `irq_addr` pulses in the same cycle that `addr_flag` sets. Both appear one clock after `word_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| word_valid | input | 1 | Received word complete, one cycle |
| word_data | input | DATA_W | Received data bits |
| word_bit9 | input | 1 | Ninth bit of the received word |
| brk_pulse | input | 1 | Break detected, one cycle |
| match_char | input | DATA_W | Character compared against received words |
| word_len | input | LEN_W | Word length minus MIN_LEN |
| addr_en | input | 1 | Address mode enable |
| addr_mode | input | 1 | Mode bit paired with addr_en |
| brk_sel | input | 1 | Selects post-break matching when addr_en and addr_mode are both 1 |
| flag_clr | input | 1 | Clears addr_flag and overrun |
| rd_ack | input | 1 | Buffer read, clears rx_ready |
| rx_buf | output | DATA_W | Receive buffer |
| rx_ready | output | 1 | Buffer holds unread data |
| addr_flag | output | 1 | Address or character match seen |
| overrun | output | 1 | Word held back because addr_flag was set |
| irq_rx | output | 1 | Buffer-write interrupt pulse |
| irq_addr | output | 1 | Match interrupt pulse |

## Verification
The bench builds the block with its defaults, DATA_W=8 and MIN_LEN=5. The two-bit `word_len` therefore covers every word length from 5 to 8 bits, so the forced-one upper bits and the masked character compare are both exercised. At 8 bits no bit is masked, which tests the exact-match boundary. Random stimulus draws many words from the match character itself. It also inserts break pulses just before words, so matches, post-break addresses and overruns occur often in every mode.

// File: rtl/uart_rx_addr_filter.sv
module uart_rx_addr_filter #(
  parameter int DATA_W  = 8,
  parameter int MIN_LEN = 5,
  parameter int LEN_W   = $clog2(DATA_W - MIN_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_valid,
  input  logic [DATA_W-1:0] word_data,
  input  logic              word_bit9,
  input  logic              brk_pulse,
  input  logic [DATA_W-1:0] match_char,
  input  logic [LEN_W-1:0]  word_len,
  input  logic              addr_en,
  input  logic              addr_mode,
  input  logic              brk_sel,
  input  logic              flag_clr,
  input  logic              rd_ack,
  output logic [DATA_W-1:0] rx_buf,
  output logic              rx_ready,
  output logic              addr_flag,
  output logic              overrun,
  output logic              irq_rx,
  output logic              irq_addr
);

  logic [DATA_W-1:0] used_mask;
  logic after_brk, win;

  always_comb begin
    for (int i = 0; i < DATA_W; i++)
      used_mask[i] = (i < MIN_LEN + int'(word_len));
  end

  wire char_eq    = ((word_data ^ match_char) & used_mask) == '0;
  wire brk_mode   = addr_en & addr_mode & brk_sel;
  wire is_addr    = addr_en & (brk_mode ? after_brk : word_bit9);
  wire addr_hit   = !addr_mode ? 1'b1 : (brk_mode ? (char_eq | word_bit9) : char_eq);
  wire search_hit = !addr_en & addr_mode & char_eq;
  wire fwd        = !is_addr & (!addr_en | win);
  wire do_write   = word_valid & fwd & !addr_flag;
  wire do_ovr     = word_valid & fwd & addr_flag;
  wire set_flag   = word_valid & ((is_addr & addr_hit) | search_hit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_buf    <= '0;
      rx_ready  <= 1'b0;
      addr_flag <= 1'b0;
      overrun   <= 1'b0;
      irq_rx    <= 1'b0;
      irq_addr  <= 1'b0;
      after_brk <= 1'b0;
      win       <= 1'b0;
    end else begin
      if (do_write) rx_buf <= word_data | ~used_mask;
      if (word_valid && is_addr) win <= addr_hit;
      rx_ready  <= do_write | (rx_ready & !rd_ack);
      addr_flag <= set_flag | (addr_flag & !flag_clr);
      overrun   <= do_ovr | (overrun & !flag_clr);
      irq_rx    <= do_write;
      irq_addr  <= set_flag;
      after_brk <= brk_pulse | (after_brk & !word_valid);
    end
  end

endmodule

// File: rtl/uart_rx_addr_filter_chk.sv
module uart_rx_addr_filter_chk #(
  parameter int DATA_W  = 8,
  parameter int MIN_LEN = 5,
  parameter int LEN_W   = $clog2(DATA_W - MIN_LEN + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              word_valid,
  input logic [DATA_W-1:0] word_data,
  input logic              word_bit9,
  input logic              brk_pulse,
  input logic [DATA_W-1:0] match_char,
  input logic [LEN_W-1:0]  word_len,
  input logic              addr_en,
  input logic              addr_mode,
  input logic              brk_sel,
  input logic              flag_clr,
  input logic              rd_ack,
  input logic [DATA_W-1:0] rx_buf,
  input logic              rx_ready,
  input logic              addr_flag,
  input logic              overrun,
  input logic              irq_rx,
  input logic              irq_addr
);

  a_r11_rx_irq_with_ready: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rx |-> rx_ready);

  a_r11_addr_irq_with_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq_addr |-> addr_flag);

  a_r2_pass_no_match: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && !addr_en && !addr_mode) |=> !irq_addr);

  a_r7_addr_not_buffered: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && addr_en) |=> !(irq_addr && irq_rx));

  a_r9_no_write_when_flagged: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && addr_flag) |=> !irq_rx);

  a_r8_upper_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && word_len == '0) |=> (!irq_rx || (&rx_buf[DATA_W-1:MIN_LEN])));

  a_r10_ready_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ack && !word_valid) |=> !rx_ready);

  a_r10_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !word_valid) |=> (!addr_flag && !overrun));

endmodule

bind uart_rx_addr_filter uart_rx_addr_filter_chk #(
  .DATA_W(DATA_W), .MIN_LEN(MIN_LEN), .LEN_W(LEN_W)
) chk_i (.*);

// File: tb/uart_rx_addr_filter_tb_top.sv
`timescale 1ns/1ps
module uart_rx_addr_filter_tb_top;
  localparam int DW = 8, ML = 5, LW = 2;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, word_valid = 0, word_bit9 = 0, brk_pulse = 0;
  logic addr_en = 0, addr_mode = 0, brk_sel = 0, flag_clr = 0, rd_ack = 0;
  logic [DW-1:0] word_data = '0, match_char = 8'h0D;
  logic [LW-1:0] word_len = 2'd3;
  logic [DW-1:0] rx_buf;
  logic rx_ready, addr_flag, overrun, irq_rx, irq_addr;

  uart_rx_addr_filter #(.DATA_W(DW), .MIN_LEN(ML), .LEN_W(LW)) dut_i (.*);

  int checks = 0, errors = 0;
  logic [DW-1:0] m_buf;
  logic m_rdy, m_flag, m_ovr, m_irx, m_iad, m_brk, m_win;

  function automatic logic [DW-1:0] mask_of(logic [LW-1:0] l);
    return DW'((1 << (ML + int'(l))) - 1);
  endfunction

  task automatic model_reset();
    m_buf = '0; {m_rdy, m_flag, m_ovr, m_irx, m_iad, m_brk, m_win} = '0;
  endtask

  task automatic model_edge();
    logic [DW-1:0] mk; logic eq, adr, hit, srch, fw, wr, ov, setf;
    mk   = mask_of(word_len);
    eq   = ((word_data & mk) == (match_char & mk));
    adr  = 0; hit = 0; srch = 0;
    if (!addr_en) srch = addr_mode && eq;
    else if (!addr_mode) begin adr = word_bit9; hit = 1; end
    else if (!brk_sel) begin adr = word_bit9; hit = eq; end
    else begin adr = m_brk; hit = eq || word_bit9; end
    fw   = !adr && (!addr_en || m_win);
    wr   = word_valid && fw && !m_flag;
    ov   = word_valid && fw && m_flag;
    setf = word_valid && ((adr && hit) || srch);
    if (wr) m_buf = word_data | ~mk;
    if (word_valid && adr) m_win = hit;
    m_rdy  = wr || (m_rdy && !rd_ack);
    m_flag = setf || (m_flag && !flag_clr);
    m_ovr  = ov || (m_ovr && !flag_clr);
    m_irx  = wr; m_iad = setf;
    m_brk  = brk_pulse || (m_brk && !word_valid);
  endtask

  task automatic compare(string tag);
    checks++;
    if ({rx_buf, rx_ready, addr_flag, overrun, irq_rx, irq_addr} !==
        {m_buf, m_rdy, m_flag, m_ovr, m_irx, m_iad}) begin
      errors++;
      $display("FAIL %s: buf/rdy/flag/ovr/irx/iad actual %h %b%b%b%b%b expected %h %b%b%b%b%b",
        tag, rx_buf, rx_ready, addr_flag, overrun, irq_rx, irq_addr,
        m_buf, m_rdy, m_flag, m_ovr, m_irx, m_iad);
    end
  endtask

  task automatic cyc(string tag);
    @(posedge clk); model_edge(); #1; compare(tag);
    @(negedge clk);
    word_valid = 0; brk_pulse = 0; flag_clr = 0; rd_ack = 0;
  endtask

  task automatic word(logic [DW-1:0] d, logic b9, string tag);
    word_valid = 1; word_data = d; word_bit9 = b9; cyc(tag);
  endtask

  task automatic mode(logic e, logic m, logic b);
    addr_en = e; addr_mode = m; brk_sel = b;
  endtask

  task automatic expect_buf(logic [DW-1:0] v, string tag);
    checks++;
    if (rx_buf !== v) begin
      errors++;
      $display("FAIL %s: rx_buf actual %h expected %h", tag, rx_buf, v);
    end
  endtask

  function automatic string tag_of();
    if (!addr_en) return addr_mode ? "R3" : "R2";
    if (!addr_mode) return "R4";
    return brk_sel ? "R6" : "R5";
  endfunction

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not end, actual running expected done");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    compare("R1 reset state");
    // R1: window closed after reset
    mode(1, 0, 0);
    word(8'h11, 0, "R1 window closed");
    // R4 / R7 / R9 / R10
    word(8'h42, 1, "R4 address");
    expect_buf(8'h00, "R7 address not buffered");
    word(8'h21, 0, "R9 overrun");
    expect_buf(8'h00, "R9 buffer held");
    flag_clr = 1; cyc("R10 flag clear");
    word(8'h33, 0, "R4 data after address");
    expect_buf(8'h33, "R4 data buffered");
    rd_ack = 1; cyc("R10 ready clear");
    // R5
    mode(1, 1, 0);
    word(8'h0D, 1, "R5 matched address");
    flag_clr = 1; cyc("R10 flag clear");
    word(8'h44, 0, "R5 data forwarded");
    word(8'h55, 1, "R5 unmatched address");
    word(8'h66, 0, "R5 data dropped");
    expect_buf(8'h44, "R5 buffer unchanged");
    // R6
    mode(1, 1, 1);
    brk_pulse = 1; cyc("R6 break");
    word(8'h20, 0, "R6 post-break mismatch");
    word(8'h77, 0, "R6 data dropped");
    brk_pulse = 1; cyc("R6 break");
    word(8'h0D, 0, "R6 post-break match");
    flag_clr = 1; cyc("R10 flag clear");
    word(8'h88, 1, "R6 ninth bit is data");
    expect_buf(8'h88, "R6 ninth-bit word buffered");
    brk_pulse = 1; cyc("R6 break");
    word(8'h99, 1, "R6 post-break ninth bit match");
    flag_clr = 1; cyc("R10 flag clear");
    // R3
    mode(0, 1, 0);
    word(8'h0D, 0, "R3 search hit");
    expect_buf(8'h0D, "R3 hit buffered");
    flag_clr = 1; cyc("R10 flag clear");
    // R2 / R8
    mode(0, 0, 0);
    word_len = 2'd0;
    word(8'h05, 0, "R2 pass short");
    expect_buf(8'hE5, "R8 upper ones");
    mode(0, 1, 0);
    word(8'h0D | 8'hE0, 0, "R8 masked compare");
    flag_clr = 1; cyc("R10 flag clear");
    word_len = 2'd3;
    word(8'h8D, 0, "R8 full-width no match");
    // random
    for (int blk = 0; blk < 20; blk++) begin
      mode($urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1));
      word_len   = LW'($urandom_range(0, 3));
      match_char = DW'($urandom);
      for (int k = 0; k < 200; k++) begin
        word_valid = ($urandom_range(0, 1) == 1);
        word_data  = ($urandom_range(0, 2) == 0) ? match_char : DW'($urandom);
        word_bit9  = ($urandom_range(0, 3) == 0);
        brk_pulse  = ($urandom_range(0, 9) == 0);
        flag_clr   = ($urandom_range(0, 4) == 0);
        rd_ack     = ($urandom_range(0, 4) == 0);
        cyc({tag_of(), " random"});
      end
    end
    summary();
    $finish;
  end
endmodule